// File: doc/BRIEF.md
# PCM Time-Slot Serial Transmitter

This block places one voice sample per frame onto a shared PCM highway data line. A frame begins when the frame-sync input is seen high on a rising bit-clock edge. The block counts bit clocks from that edge and drives its word during a time slot. The slot is chosen by a programmable start index, counted in units of eight bit clocks. At every other time the data line is released so other devices on the highway can use it. The sample is either sent as 16-bit two's-complement linear data, or compressed to an 8-bit code by an A-law or μ-law compressor that is part of the block.

Two controls protect the shared line. First, nothing is driven until the host sets the transmit enable. The enable gates both the output-enable of the data line and the slot-active indicator. Second, an adjacent-slot release option ends the drive halfway through the final bit of the slot. It does this on the falling bit-clock edge, so that a device owning the next slot can start driving without contention. The sample and all control bits are captured on the frame-sync edge and apply to that whole frame.

Top module: `pcm_slot_tx`

## Requirements
- R1: After reset, and until the first frame sync that is sampled while enabled, `dx_oe`, `slot_act` and `dx` are all 0.
- R2: `tx_en` is captured at each frame-sync edge. While the captured value is 0, `dx_oe` and `slot_act` stay 0 for the whole frame. A change of `tx_en` in mid-frame has no effect until the next frame sync.
- R3: The rising edge where `fsync` is sampled high is frame edge 0. The slot is active from rising edge 8*`slot_idx`+1 for 8 bit clocks (companded) or 16 bit clocks (linear), and `slot_act` is high for exactly those bit periods.
- R4: With `adj_rel`=0 captured, `dx_oe` is high for the full bit time of every bit of an active slot.
- R5: With `adj_rel`=1 captured, `dx_oe` falls on the falling bit-clock edge inside the last bit of the slot. `slot_act` still stays high for that whole bit.
- R6: With `lin_mode`=0 and `law_mu`=0, the 8-bit A-law code is sent MSB first. To form it, take v = x>>3 for x≥0 or (−x−1)>>3 for x<0, with the sign bit 1 for x≥0. The segment s is the smallest value with v < 32·2^s. The mantissa is (v>>1)&15 for s=0 and (v>>s)&15 otherwise. The code is {sign,s[2:0],mantissa} XOR 0x55.
- R7: With `lin_mode`=0 and `law_mu`=1, the 8-bit μ-law code is sent MSB first. To form it, take m = min(|x|,32635)+0x84, with the sign bit 1 for x<0. The exponent e is the smallest value with m < 256·2^e. The code is the complement of {sign,e[2:0],(m>>(e+3))&15}.
- R8: With `lin_mode`=1, the 16-bit `sample` is sent MSB first and `law_mu` is ignored.
- R9: `dx` is 0 whenever `dx_oe` is 0.
- R10: The word sent in a frame is formed from `sample` as it was on the frame-sync edge. Later changes of `sample` do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Bit clock of the PCM highway |
| rst | input | 1 | Synchronous active-high reset |
| fsync | input | 1 | Frame sync, sampled on the rising bit-clock edge |
| slot_idx | input | SLOT_W | Slot start index, in units of 8 bit clocks |
| sample | input | 16 | Two's-complement linear sample |
| law_mu | input | 1 | 0 = A-law, 1 = μ-law |
| lin_mode | input | 1 | 1 = send 16-bit linear word |
| adj_rel | input | 1 | 1 = release line halfway through last bit |
| tx_en | input | 1 | Transmit enable |
| dx | output | 1 | Serial data value |
| dx_oe | output | 1 | Output enable for the data-line driver |
| slot_act | output | 1 | High during the block's time slot |

## Verification
The bench samples the outputs in both halves of every bit, so a release made on the rising edge instead of the falling edge would show as a missing first half-bit. A release that never happens would show as a driven second half. Slot indices 0 and the highest value, in both word lengths, expose an off-by-one in the window: such a design would drive a bit early or late, or would clip the last bit. Corner samples (0, −1, full scale, −32768 and values at the μ-law clip point) catch a compressor with a wrong segment search, bias or inversion mask. Changing the sample on every cycle and toggling the enable in mid-frame catch a design that reads its inputs live instead of capturing them at the frame edge.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;

    localparam int SAMPLE_W = 16;
    localparam int CODE_W   = 8;

    typedef enum logic {
        LAW_A  = 1'b0,
        LAW_MU = 1'b1
    } law_e;

    typedef struct packed {
        logic en;
        logic adj;
        logic lin;
        law_e law;
    } tx_cfg_t;

    localparam tx_cfg_t CFG_RESET = '{en: 1'b0, adj: 1'b0, lin: 1'b0, law: LAW_A};

    // 16-bit linear to 8-bit A-law
    function automatic logic [CODE_W-1:0] alaw_compress(input logic [SAMPLE_W-1:0] x);
        logic                neg;
        logic [SAMPLE_W-1:0] v;
        logic [11:0]         mag;
        logic [11:0]         sh;
        logic [2:0]          seg;
        logic [3:0]          mant;
        neg = x[SAMPLE_W-1];
        v   = neg ? ~x : x;
        mag = v[14:3];
        seg = 3'd0;
        for (int s = 1; s < 8; s++) begin
            if (mag >= (12'd16 << s)) seg = 3'(s);
        end
        sh   = mag >> seg;
        mant = (seg == 3'd0) ? mag[4:1] : sh[3:0];
        return {~neg, seg, mant} ^ 8'h55;
    endfunction

    // 16-bit linear to 8-bit mu-law
    function automatic logic [CODE_W-1:0] ulaw_compress(input logic [SAMPLE_W-1:0] x);
        logic        neg;
        logic [16:0] a;
        logic [14:0] m;
        logic [14:0] sh;
        logic [2:0]  ex;
        neg = x[SAMPLE_W-1];
        a   = neg ? (17'h1_0000 - {1'b0, x}) : {1'b0, x};
        if (a > 17'd32635) a = 17'd32635;
        m  = a[14:0] + 15'd132;
        ex = 3'd0;
        for (int s = 1; s < 8; s++) begin
            if (m >= (15'd128 << s)) ex = 3'(s);
        end
        sh = m >> ({1'b0, ex} + 4'd3);
        return ~{neg, ex, sh[3:0]};
    endfunction

endpackage

// File: rtl/pcm_frame_timer.sv
module pcm_frame_timer #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fsync,
    output logic [CNT_W-1:0] cnt,
    output logic             seen
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            seen <= 1'b0;
        end else if (fsync) begin
            cnt  <= '0;
            seen <= 1'b1;
        end else if (cnt != CNT_MAX) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R3: bit position only moves forward between frame syncs
    p_count_forward_r3: assert property (@(posedge clk) disable iff (rst)
        !fsync |=> (cnt >= $past(cnt)));

    // R3: a frame sync restarts the bit position
    p_frame_restart_r3: assert property (@(posedge clk) disable iff (rst)
        fsync |=> (cnt == '0) && seen);

endmodule

// File: rtl/pcm_word_select.sv
module pcm_word_select
    import pcm_tx_pkg::*;
(
    input  logic [SAMPLE_W-1:0] sample,
    input  logic                lin,
    input  law_e                law,
    output logic [SAMPLE_W-1:0] word,
    output logic [3:0]          last_idx
);
    logic [CODE_W-1:0] code_a;
    logic [CODE_W-1:0] code_u;
    logic [CODE_W-1:0] code_sel;

    always_comb begin
        code_a   = alaw_compress(sample);
        code_u   = ulaw_compress(sample);
        code_sel = (law == LAW_MU) ? code_u : code_a;
        if (lin) begin
            word     = sample;
            last_idx = 4'(SAMPLE_W - 1);
        end else begin
            word     = {code_sel, {(SAMPLE_W-CODE_W){1'b0}}};
            last_idx = 4'(CODE_W - 1);
        end
    end

endmodule

// File: rtl/pcm_slot_driver.sv
module pcm_slot_driver
    import pcm_tx_pkg::*;
#(
    parameter int SLOT_W = 5,
    parameter int CNT_W  = 9
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                fsync,
    input  logic [SLOT_W-1:0]   slot_idx,
    input  logic [SAMPLE_W-1:0] word_in,
    input  logic [3:0]          last_in,
    input  tx_cfg_t             cfg_in,
    input  logic [CNT_W-1:0]    cnt,
    input  logic                seen,
    output logic                dx,
    output logic                dx_oe,
    output logic                slot_act
);
    tx_cfg_t             cfg_q;
    logic [SAMPLE_W-1:0] word_q;
    logic [3:0]          last_q;
    logic [SLOT_W-1:0]   slot_q;
    logic [CNT_W-1:0]    base;
    logic [CNT_W-1:0]    idx;
    logic                in_win;
    logic                last_bit;
    logic                half_rel;

    // capture everything that shapes the frame on the sync edge
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= CFG_RESET;
            word_q <= '0;
            last_q <= 4'(CODE_W - 1);
            slot_q <= '0;
        end else if (fsync) begin
            cfg_q  <= cfg_in;
            word_q <= word_in;
            last_q <= last_in;
            slot_q <= slot_idx;
        end
    end

    always_comb begin
        base     = CNT_W'({slot_q, 3'b000}) + 1'b1;
        idx      = cnt - base;
        in_win   = seen && (cnt >= base) && (idx <= CNT_W'(last_q));
        slot_act = in_win && cfg_q.en;
        last_bit = in_win && (idx == CNT_W'(last_q));
    end

    // second-half release of the final bit, timed from the falling edge
    always_ff @(negedge clk) begin
        if (rst) half_rel <= 1'b0;
        else     half_rel <= slot_act && last_bit && cfg_q.adj;
    end

    always_comb begin
        dx_oe = slot_act && !half_rel;
        dx    = dx_oe && word_q[4'(SAMPLE_W-1) - idx[3:0]];
    end

    // R1/R2: nothing on the line without a captured enable
    p_quiet_when_off_r2: assert property (@(posedge clk) disable iff (rst)
        !cfg_q.en |-> !dx_oe && !slot_act);

    // R3: the driver is only on inside the slot
    p_oe_inside_slot_r3: assert property (@(posedge clk) disable iff (rst)
        dx_oe |-> slot_act);

    // R4: full-bit drive without the release option
    p_full_drive_r4: assert property (@(posedge clk) disable iff (rst)
        slot_act && !cfg_q.adj |-> dx_oe);

    // R5: second half of the final bit is released
    p_half_release_r5: assert property (@(posedge clk) disable iff (rst)
        slot_act && last_bit && cfg_q.adj |-> !dx_oe);

    // R9: data is low whenever the driver is off
    p_data_low_off_r9: assert property (@(posedge clk) disable iff (rst)
        !dx_oe |-> !dx);

endmodule

// File: rtl/pcm_slot_tx.sv
module pcm_slot_tx
    import pcm_tx_pkg::*;
#(
    parameter int SLOT_W = 5
) (
    input  logic                clk_bit,
    input  logic                rst,
    input  logic                fsync,
    input  logic [SLOT_W-1:0]   slot_idx,
    input  logic [15:0]         sample,
    input  logic                law_mu,
    input  logic                lin_mode,
    input  logic                adj_rel,
    input  logic                tx_en,
    output logic                dx,
    output logic                dx_oe,
    output logic                slot_act
);
    localparam int SPAN  = (1 << SLOT_W) * 8 + SAMPLE_W + 2;
    localparam int CNT_W = $clog2(SPAN) + 1;

    logic [CNT_W-1:0]    cnt;
    logic                seen;
    logic [SAMPLE_W-1:0] word;
    logic [3:0]          last_idx;
    tx_cfg_t             cfg_in;

    always_comb begin
        cfg_in.en  = tx_en;
        cfg_in.adj = adj_rel;
        cfg_in.lin = lin_mode;
        cfg_in.law = law_mu ? LAW_MU : LAW_A;
    end

    pcm_frame_timer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk_bit),
        .rst   (rst),
        .fsync (fsync),
        .cnt   (cnt),
        .seen  (seen)
    );

    pcm_word_select u_word (
        .sample   (sample),
        .lin      (cfg_in.lin),
        .law      (cfg_in.law),
        .word     (word),
        .last_idx (last_idx)
    );

    pcm_slot_driver #(.SLOT_W(SLOT_W), .CNT_W(CNT_W)) u_drv (
        .clk      (clk_bit),
        .rst      (rst),
        .fsync    (fsync),
        .slot_idx (slot_idx),
        .word_in  (word),
        .last_in  (last_idx),
        .cfg_in   (cfg_in),
        .cnt      (cnt),
        .seen     (seen),
        .dx       (dx),
        .dx_oe    (dx_oe),
        .slot_act (slot_act)
    );

endmodule

// File: tb/pcm_slot_tx_bench.sv
module pcm_slot_tx_bench;
    localparam int CLK_P  = 10;
    localparam int SLOT_W = 5;
    localparam int FRAME  = 272;

    logic clk_bit = 1'b0;
    logic rst = 1'b1;
    logic fsync = 1'b0;
    logic [SLOT_W-1:0] slot_idx = '0;
    logic [15:0] sample = '0;
    logic law_mu = 1'b0, lin_mode = 1'b0, adj_rel = 1'b0, tx_en = 1'b0;
    logic dx, dx_oe, slot_act;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    pcm_slot_tx #(.SLOT_W(SLOT_W)) u_pcm_slot_tx (
        .clk_bit(clk_bit), .rst(rst), .fsync(fsync), .slot_idx(slot_idx),
        .sample(sample), .law_mu(law_mu), .lin_mode(lin_mode),
        .adj_rel(adj_rel), .tx_en(tx_en),
        .dx(dx), .dx_oe(dx_oe), .slot_act(slot_act)
    );

    always #(CLK_P/2) clk_bit = ~clk_bit;

    // reference compressors, written from R6 and R7
    function automatic int ref_alaw(input int x);
        int v, s, mt, sg;
        sg = (x >= 0) ? 1 : 0;
        v  = (x >= 0) ? (x >> 3) : ((-x - 1) >> 3);
        s  = 0;
        while (s < 7 && v >= (32 << s)) s++;
        mt = (s == 0) ? ((v >> 1) & 15) : ((v >> s) & 15);
        return ((sg << 7) | (s << 4) | mt) ^ 'h55;
    endfunction

    function automatic int ref_ulaw(input int x);
        int m, e, sg;
        sg = (x < 0) ? 1 : 0;
        m  = (x < 0) ? -x : x;
        if (m > 32635) m = 32635;
        m = m + 'h84;
        e = 0;
        while (e < 7 && m >= (256 << e)) e++;
        return (~((sg << 7) | (e << 4) | ((m >> (e + 3)) & 15))) & 'hFF;
    endfunction

    // behavioural model state
    int  m_cnt = 0;
    bit  m_seen = 0, m_en = 0, m_adj = 0, m_lin = 0, m_mu = 0;
    int  m_slot = 0;
    int  m_word = 0;

    task automatic check(input string tag, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s at %0t: actual=%0b expected=%0b", tag, what, $time, act, exp);
        end
    endtask

    task automatic compare(input bit second_half);
        int base, len, idx;
        bit win, e_act, e_oe, e_dx;
        string t_act, t_oe, t_dx;
        base  = m_slot * 8 + 1;
        len   = m_lin ? 16 : 8;
        idx   = m_cnt - base;
        win   = m_seen && m_cnt >= base && idx < len;
        e_act = win && m_en;
        e_oe  = e_act && !(second_half && m_adj && idx == len - 1);
        e_dx  = e_oe && m_word[15 - idx];
        t_act = !m_seen ? "R1" : (!m_en ? "R2" : "R3");
        t_oe  = !e_act ? t_act : ((m_adj && idx == len - 1) ? "R5" : "R4");
        t_dx  = !e_oe ? "R9" : (m_lin ? "R8/R10" : (m_mu ? "R7/R10" : "R6/R10"));
        check(t_act, "slot_act", slot_act, e_act);
        check(t_oe, "dx_oe", dx_oe, e_oe);
        check(t_dx, "dx", dx, e_dx);
    endtask

    always begin
        @(posedge clk_bit);
        if (rst) begin
            m_cnt = 0; m_seen = 0; m_en = 0; m_adj = 0; m_lin = 0; m_mu = 0; m_slot = 0; m_word = 0;
        end else if (fsync) begin
            m_cnt = 0; m_seen = 1; m_en = tx_en; m_adj = adj_rel; m_lin = lin_mode; m_mu = law_mu;
            m_slot = int'(slot_idx);
            if (lin_mode)    m_word = int'(sample);
            else if (law_mu) m_word = ref_ulaw(int'($signed(sample))) << 8;
            else             m_word = ref_alaw(int'($signed(sample))) << 8;
        end else begin
            m_cnt++;
        end
        #3;
        if (!done) compare(1'b0);
        #4;
        if (!done) compare(1'b1);
    end

    function automatic logic [15:0] corner(input int k);
        case (k % 12)
            0: return 16'h0000;  1: return 16'hFFFF;  2: return 16'h7FFF;
            3: return 16'h8000;  4: return 16'd32635; 5: return 16'd32636;
            6: return 16'h0001;  7: return 16'd31;    8: return 16'd32;
            9: return 16'hF000; 10: return 16'h1234;
            default: return 16'($urandom);
        endcase
    endfunction

    // one frame: controls and sample are presented with the sync,
    // the sample then changes every cycle (R10) and tx_en may toggle (R2)
    task automatic run_frame(input int slot, input bit mu, input bit lin, input bit adj,
                             input bit en, input logic [15:0] s, input int toggle_at);
        @(posedge clk_bit); #1;
        fsync = 1'b1; slot_idx = SLOT_W'(slot); law_mu = mu; lin_mode = lin;
        adj_rel = adj; tx_en = en; sample = s;
        for (int i = 1; i < FRAME; i++) begin
            @(posedge clk_bit); #1;
            fsync  = 1'b0;
            sample = 16'($urandom);
            law_mu = ~law_mu; lin_mode = ~lin_mode; adj_rel = ~adj_rel;
            if (i == toggle_at) tx_en = ~tx_en;
        end
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired at %0t", $time);
        finish_run();
    end

    initial begin
        int k;
        k = 0;
        repeat (4) @(posedge clk_bit);
        #1 rst = 1'b0;
        // R1: enabled but no frame sync yet
        tx_en = 1'b1;
        repeat (30) begin
            @(posedge clk_bit); #1 sample = 16'($urandom);
        end
        for (int combo = 0; combo < 8; combo++) begin
            for (int si = 0; si < 3; si++) begin
                int slot;
                slot = (si == 0) ? 0 : ((si == 1) ? 5 : (1 << SLOT_W) - 1);
                run_frame(slot, combo[0], combo[1], combo[2], 1'b1, corner(k), 0);
                k++;
            end
        end
        // extra corner samples in each companded law
        for (int j = 0; j < 12; j++) begin
            run_frame(j % 4, j[0], 1'b0, j[1], 1'b1, corner(j), 0);
        end
        // R2: disabled frame, then enable toggled mid-frame both ways
        run_frame(2, 1'b0, 1'b1, 1'b0, 1'b0, 16'h5A5A, 10);
        run_frame(2, 1'b1, 1'b0, 1'b1, 1'b1, 16'hA5A5, 10);
        run_frame(0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h4000, 3);
        @(posedge clk_bit); #1;
        // R1: reset mid-activity returns outputs to quiet
        rst = 1'b1;
        repeat (3) @(posedge clk_bit);
        #1 rst = 1'b0;
        repeat (20) @(posedge clk_bit);
        #8;
        finish_run();
    end

endmodule